// File: doc/BRIEF.md
# PLL Control Register Sequencer

This block owns the two 32-bit control words that configure an analog phase-locked loop and steps them through a safe reprogramming order. A start pulse supplies the true feedback, reference and output divider values. The block stores each one minus one in its field and derives a loop-bandwidth field from the encoded feedback value.

It first holds the loop in reset and bypass while the new dividers are loaded. It then waits a fixed settling time measured in system clock cycles. Next it releases reset with fast-lock enabled while still in bypass, and counts divided-reference periods, supplied as a one-cycle tick from the reference clock domain. Finally it drops fast-lock and bypass together and raises done for one cycle.

A registered rate output shows the frequency the live control words produce from a given input frequency. The analog loop itself, any bus interface and the choice of divider values are left to the surrounding logic.

Top module: `pll_ctl_seq`

## Requirements
- R1: While reset is asserted, and after it, until a start is accepted, both control words read zero and busy and done are low. Reset may be asserted in the middle of a sequence and clears the same state.
- R2: Control word 0 carries the output divider minus one at bits 2:0 and the feedback divider minus one at bits 16:4. Bits 31:20 carry the encoded feedback value shifted right by one. All other bits are zero.
- R3: Control word 1 carries the reference divider minus one at bits 5:0. The flags are loop reset at bit 28, fast-lock at bit 27, saturation enable at bit 26, bypass at bit 25 and power-down at bit 24. Power-down is never set, and all other bits are zero.
- R4: The clock edge that accepts start loads word 1 with loop reset, saturation and bypass set and the new reference field. The next edge loads word 0 with the new dividers.
- R5: Exactly SETTLE_US × CYC_PER_US cycles after the word 0 load, word 1 changes in a single update: loop reset clears and fast-lock sets, while bypass and saturation stay set.
- R6: While fast-lock is set, the block counts ref_tick pulses; ticks that arrive before this phase are not counted. On the edge after 500 × R + LOCK_MARGIN ticks have been counted, fast-lock and bypass clear together, saturation remains set, and done is high for exactly one cycle.
- R7: busy goes high on the edge that accepts start and falls on the edge that raises done. A start that arrives while busy is ignored, and the dividers of the running sequence are kept.
- R8: When word 1 has bypass set, f_out equals f_in one cycle later.
- R9: When bypass is clear, f_out equals floor(f_in × F / (2 × R × OD)) one cycle later, where F, R and OD are the true dividers decoded from the live words. With both words at zero this is f_in / 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to reprogram with the given dividers |
| fb_div | input | 14 | True feedback divider, 1 to 8192 |
| ref_div | input | 7 | True reference divider, 1 to 64 |
| out_div | input | 4 | True output divider, 1 to 8 |
| ref_tick | input | 1 | One-cycle pulse per divided reference period |
| f_in | input | 32 | Input reference frequency |
| ctl0 | output | 32 | Control word 0 (dividers and bandwidth) |
| ctl1 | output | 32 | Control word 1 (flags and reference divider) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| f_out | output | 32 | Output frequency implied by the live words |

## Verification
Some properties are checked on every cycle. Power-down must stay low. Fast-lock may only appear with loop reset clear and bypass set. A sequence must begin with reset, bypass and saturation all set. The latched dividers may not change mid-sequence, and the settle and lock counters must stay within their bounds. A bypassed word must pass f_in straight through, and done must be a single-cycle pulse that coincides with bypass clear and busy low.

Other behaviour can only be shown by the bench's scenarios. These cover the exact settling length, the exact tick count under several tick spacings, the computed field and frequency values at the divider extremes, and the rejection of a second start. They also show that ticks arriving during the settle wait are not counted and that a reset mid-sequence clears everything.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  // control word 0 layout
  localparam int OD_W   = 3;
  localparam int OD_LSB = 0;
  localparam int FB_W   = 13;
  localparam int FB_LSB = 4;
  localparam int BW_W   = 12;
  localparam int BW_LSB = 20;
  // control word 1 layout
  localparam int REF_W    = 6;
  localparam int REF_LSB  = 0;
  localparam int PD_BIT   = 24;
  localparam int BYP_BIT  = 25;
  localparam int SAT_BIT  = 26;
  localparam int FAST_BIT = 27;
  localparam int RST_BIT  = 28;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_WR0    = 2'd1,
    SQ_SETTLE = 2'd2,
    SQ_LOCK   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [FB_W-1:0]  fb;
    logic [REF_W-1:0] rf;
    logic [OD_W-1:0]  od;
  } div_code_t;

  typedef struct packed {
    logic rst;
    logic fast;
    logic sat;
    logic byp;
  } ctl_flags_t;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_seq_pkg::*;
(
  input  div_code_t   code,
  input  ctl_flags_t  flags,
  output logic [31:0] word0,
  output logic [31:0] word1
);
  always_comb begin
    word0 = '0;
    word0[OD_LSB +: OD_W] = code.od;
    word0[FB_LSB +: FB_W] = code.fb;
    word0[BW_LSB +: BW_W] = BW_W'(code.fb >> 1);
  end

  always_comb begin
    word1 = '0;
    word1[REF_LSB +: REF_W] = code.rf;
    word1[RST_BIT]  = flags.rst;
    word1[FAST_BIT] = flags.fast;
    word1[SAT_BIT]  = flags.sat;
    word1[BYP_BIT]  = flags.byp;
    word1[PD_BIT]   = 1'b0;
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int CYC_PER_US      = 250,
  parameter int SETTLE_US       = 5,
  parameter int LOCK_REF_CYCLES = 500,
  parameter int LOCK_MARGIN     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  div_code_t  in_code,
  input  logic       ref_tick,
  output div_code_t  code_nx,
  output ctl_flags_t flags_nx,
  output logic       ld0,
  output logic       ld1,
  output logic       busy,
  output logic       done
);
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int TMR_W      = $clog2(SETTLE_CYC + 1);
  localparam int CNT_MAX    = LOCK_REF_CYCLES * (2 ** REF_W) + LOCK_MARGIN;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  seq_state_e       state_q, state_d;
  div_code_t        code_q;
  ctl_flags_t       flags_q;
  logic [TMR_W-1:0] timer_q, timer_d;
  logic [CNT_W-1:0] refcnt_q, refcnt_d;
  logic [CNT_W-1:0] lock_tgt;
  logic             busy_q, busy_d, done_q, done_d;

  // 500 * (rf + 1) + margin, written as 500 * rf + (500 + margin)
  assign lock_tgt = CNT_W'(LOCK_REF_CYCLES) * CNT_W'(code_q.rf)
                  + CNT_W'(LOCK_REF_CYCLES + LOCK_MARGIN);

  always_comb begin
    state_d  = state_q;
    code_nx  = code_q;
    flags_nx = flags_q;
    timer_d  = timer_q;
    refcnt_d = refcnt_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    ld0      = 1'b0;
    ld1      = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          code_nx  = in_code;
          flags_nx = '{rst: 1'b1, fast: 1'b0, sat: 1'b1, byp: 1'b1};
          ld1      = 1'b1;
          busy_d   = 1'b1;
          state_d  = SQ_WR0;
        end
      end
      SQ_WR0: begin
        ld0     = 1'b1;
        timer_d = '0;
        state_d = SQ_SETTLE;
      end
      SQ_SETTLE: begin
        if (timer_q == TMR_W'(SETTLE_CYC - 1)) begin
          flags_nx.rst  = 1'b0;
          flags_nx.fast = 1'b1;
          ld1           = 1'b1;
          refcnt_d      = '0;
          state_d       = SQ_LOCK;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      SQ_LOCK: begin
        if (refcnt_q >= lock_tgt) begin
          flags_nx.fast = 1'b0;
          flags_nx.byp  = 1'b0;
          ld1           = 1'b1;
          done_d        = 1'b1;
          busy_d        = 1'b0;
          state_d       = SQ_IDLE;
        end else if (ref_tick) begin
          refcnt_d = refcnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      code_q   <= '0;
      flags_q  <= '0;
      timer_q  <= '0;
      refcnt_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_nx;
      flags_q  <= flags_nx;
      timer_q  <= timer_d;
      refcnt_q <= refcnt_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |=> $stable(code_q));

  // R5
  settle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_SETTLE) |-> (timer_q < TMR_W'(SETTLE_CYC)));

  // R6
  lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_LOCK) |-> (refcnt_q <= lock_tgt));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pll_seq_pkg::*;
#(
  parameter int FIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FIN_W-1:0] f_in,
  input  logic [FB_W-1:0]  fb_enc,
  input  logic [REF_W-1:0] rf_enc,
  input  logic [OD_W-1:0]  od_enc,
  input  logic             byp,
  output logic [FIN_W-1:0] f_out
);
  localparam int NUM_W = FIN_W + FB_W + 1;
  localparam int DEN_W = REF_W + OD_W + 3;

  logic [NUM_W-1:0] num, quo;
  logic [DEN_W-1:0] den;
  logic [FIN_W-1:0] f_d, f_q;

  assign num = NUM_W'(f_in) * (NUM_W'(fb_enc) + NUM_W'(1));
  assign den = ((DEN_W'(rf_enc) + DEN_W'(1)) * (DEN_W'(od_enc) + DEN_W'(1))) << 1;
  assign quo = num / NUM_W'(den);
  assign f_d = byp ? f_in : quo[FIN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign f_out = f_q;

  // R8
  byp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> (f_out == $past(f_in)));
endmodule

// File: rtl/pll_ctl_seq.sv
module pll_ctl_seq
  import pll_seq_pkg::*;
#(
  parameter int CYC_PER_US      = 250,
  parameter int SETTLE_US       = 5,
  parameter int LOCK_REF_CYCLES = 500,
  parameter int LOCK_MARGIN     = 16,
  parameter int FIN_W           = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FB_W:0]    fb_div,
  input  logic [REF_W:0]   ref_div,
  input  logic [OD_W:0]    out_div,
  input  logic             ref_tick,
  input  logic [FIN_W-1:0] f_in,
  output logic [31:0]      ctl0,
  output logic [31:0]      ctl1,
  output logic             busy,
  output logic             done,
  output logic [FIN_W-1:0] f_out
);
  logic [1:0]  rst_sync;
  logic        rst_n_s;
  div_code_t   in_code, code_nx;
  ctl_flags_t  flags_nx;
  logic        ld0, ld1;
  logic [31:0] word0, word1;
  logic [31:0] ctl0_q, ctl1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  // store true divider values minus one
  assign in_code.fb = FB_W'(fb_div - 1'b1);
  assign in_code.rf = REF_W'(ref_div - 1'b1);
  assign in_code.od = OD_W'(out_div - 1'b1);

  pll_seq_fsm #(
    .CYC_PER_US     (CYC_PER_US),
    .SETTLE_US      (SETTLE_US),
    .LOCK_REF_CYCLES(LOCK_REF_CYCLES),
    .LOCK_MARGIN    (LOCK_MARGIN)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .in_code (in_code),
    .ref_tick(ref_tick),
    .code_nx (code_nx),
    .flags_nx(flags_nx),
    .ld0     (ld0),
    .ld1     (ld1),
    .busy    (busy),
    .done    (done)
  );

  pll_word_pack u_pack (
    .code (code_nx),
    .flags(flags_nx),
    .word0(word0),
    .word1(word1)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
    end else begin
      if (ld0) ctl0_q <= word0;
      if (ld1) ctl1_q <= word1;
    end
  end

  assign ctl0 = ctl0_q;
  assign ctl1 = ctl1_q;

  pll_rate_calc #(.FIN_W(FIN_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n_s),
    .f_in  (f_in),
    .fb_enc(ctl0_q[FB_LSB +: FB_W]),
    .rf_enc(ctl1_q[REF_LSB +: REF_W]),
    .od_enc(ctl0_q[OD_LSB +: OD_W]),
    .byp   (ctl1_q[BYP_BIT]),
    .f_out (f_out)
  );

  // R3
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl1_q[PD_BIT]);

  // R5
  fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl1_q[FAST_BIT] |-> (!ctl1_q[RST_BIT] && ctl1_q[BYP_BIT]));

  // R4
  seq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> (ctl1_q[RST_BIT] && ctl1_q[BYP_BIT] && ctl1_q[SAT_BIT]));

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (!busy && !ctl1_q[BYP_BIT] && !ctl1_q[FAST_BIT]));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
endmodule

// File: tb/pll_ctl_seq_tb_top.sv
module pll_ctl_seq_tb_top;
  localparam int CPU    = 10;
  localparam int MARGIN = 16;
  localparam int NSET   = 5 * CPU;

  typedef struct packed {
    logic [31:0] f;
    logic [31:0] r;
    logic [31:0] od;
    logic [31:0] p;
    logic [31:0] fin;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{f: 32'd100,  r: 32'd1,  od: 32'd2, p: 32'd1, fin: 32'd24000000},
    '{f: 32'd8192, r: 32'd64, od: 32'd8, p: 32'd1, fin: 32'd40000000},
    '{f: 32'd1,    r: 32'd2,  od: 32'd1, p: 32'd3, fin: 32'd12000000},
    '{f: 32'd513,  r: 32'd5,  od: 32'd3, p: 32'd2, fin: 32'd27000000}
  };

  logic        clk = 1'b0;
  logic        rst_n, start, ref_tick;
  logic [13:0] fb_div;
  logic [6:0]  ref_div;
  logic [3:0]  out_div;
  logic [31:0] f_in, ctl0, ctl1, f_out;
  logic        busy, done;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  pll_ctl_seq #(.CYC_PER_US(CPU), .LOCK_MARGIN(MARGIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fb_div(fb_div),
    .ref_div(ref_div), .out_div(out_div), .ref_tick(ref_tick),
    .f_in(f_in), .ctl0(ctl0), .ctl1(ctl1), .busy(busy), .done(done),
    .f_out(f_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    logic [31:0] e0, e1_cfg, e1_lock, e1_fin;
    longint      ef;
    int          n, cnt, cyc, tgt;
    logic        pend;
    e0      = (((v.f - 1) >> 1) << 20) | ((v.f - 1) << 4) | (v.od - 1);
    e1_cfg  = (32'd1 << 28) | (32'd1 << 26) | (32'd1 << 25) | (v.r - 1);
    e1_lock = (32'd1 << 27) | (32'd1 << 26) | (32'd1 << 25) | (v.r - 1);
    e1_fin  = (32'd1 << 26) | (v.r - 1);
    ef      = (longint'(v.fin) * longint'(v.f)) / longint'(2 * v.r * v.od);
    tgt     = 500 * int'(v.r) + MARGIN;
    fb_div  = 14'(v.f); ref_div = 7'(v.r); out_div = 4'(v.od);
    f_in    = v.fin; ref_tick = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 ctl1 first write", ctl1, e1_cfg);
    chk("R7 busy after start", busy, 1);
    @(negedge clk);
    chk("R2 ctl0 fields", ctl0, e0);
    chk("R8 bypass f_out", f_out, v.fin);
    n = 0; cyc = 0;
    while (ctl1 == e1_cfg && n < 100000) begin
      ref_tick = ((cyc % int'(v.p)) == 0);
      cyc++;
      if (inject && n == 3) begin
        start = 1'b1; fb_div = 14'd7; ref_div = 7'd3; out_div = 4'd5;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk("R5 settle cycles", n, NSET);
    chk("R5 ctl1 fast-lock", ctl1, e1_lock);
    cnt = 0; pend = 1'b0; cyc = 0; n = 0;
    while (!done && n < 150000) begin
      if (pend) cnt++;
      pend = ((cyc % int'(v.p)) == 0);
      ref_tick = pend;
      cyc++;
      @(negedge clk);
      n++;
    end
    ref_tick = 1'b0;
    chk("R6 done raised", done, 1);
    chk("R6 ticks counted", cnt, tgt);
    chk("R6 ctl1 released", ctl1, e1_fin);
    chk("R7 busy at done", busy, 0);
    chk("R7 ctl0 kept", ctl0, e0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R9 f_out locked", f_out, ef);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ref_tick = 1'b0;
    fb_div = 14'd1; ref_div = 7'd1; out_div = 4'd1; f_in = 32'd1000;
    repeat (3) @(negedge clk);
    chk("R1 reset ctl0", ctl0, 0);
    chk("R1 reset ctl1", ctl1, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle ctl1", ctl1, 0);
    chk("R9 zero words", f_out, 500);
    foreach (VECS[i]) run_vec(VECS[i], i == 0);
    // reset in the middle of a lock wait
    fb_div = 14'd20; ref_div = 7'd2; out_div = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NSET + 10) @(negedge clk);
    chk("R6 mid lock busy", busy, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset ctl0", ctl0, 0);
    chk("R1 mid reset ctl1", ctl1, 0);
    chk("R1 mid reset busy", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule